// File: doc/BRIEF.md
# Telemetry Burst Packet Decoder

This block takes a recovered serial bit stream from a low-power telemetry transmitter and turns each short burst into one decoded sample. Bits arrive on `bit_in` and are taken only in cycles where `bit_enable` is high. One enable arrives per recovered bit period, which is nominally about 200 ns, from a transmit clock near 5 MHz. While idle the decoder hunts for a run of ones followed by a zero. That pattern marks the end of the synchronising preamble and the start bit.

After the start bit the decoder shifts in three fields, each most significant bit first: a 4-bit channel ID, a 16-bit sample word and a 4-bit completion code. A complete burst spans 36 bit periods: 11 synchronising bits, 1 start bit, 4 ID bits, 16 data bits and 4 code bits. The set number is not sent over the air, so it arrives as the static input `set_sel`. The code must equal (15 − ID + set) truncated to 4 bits.

A good burst gives a one-cycle `pkt_valid` pulse together with the channel number (16 × set + ID) and the data word. A bad burst gives a one-cycle `pkt_error` pulse instead. In both cases the decoder then returns to hunting.

Top module: `burst_pkt_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every state element clears. After reset, `pkt_valid`, `pkt_error` and `pkt_test` are 0, and `pkt_channel` and `pkt_data` are 0.
- R2: While hunting, a zero bit that follows at least 8 consecutive one bits (the parameter MIN_PREAMBLE) is taken as the start bit. Longer runs are accepted too. A zero after 7 or fewer ones is not a start bit, so the bits that follow produce neither a valid pulse nor an error pulse.
- R3: After the start bit, the next 24 enabled bits are the ID (4 bits), then the data word (16 bits), then the completion code (4 bits), each field most significant bit first. Bits inside the payload never restart the preamble hunt, even a long run of ones.
- R4: `pkt_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the last code bit. No pulse appears before that edge.
- R5: When the received code differs from (15 − ID + set_sel) mod 16, `pkt_error` pulses for one cycle in place of `pkt_valid`. `pkt_channel` and `pkt_data` keep their previous values.
- R6: An ID of 0 or 15 gives `pkt_error` and no `pkt_valid`, even when the completion code matches.
- R7: When a burst is valid, `pkt_channel` equals 16 × set_sel + ID (set_sel in bits 7:4, ID in bits 3:0) and `pkt_data` equals the received word. `pkt_test` is high together with `pkt_valid` when set_sel is 14 or 15, and is 0 at all other times.
- R8: `bit_in` has no effect in cycles where `bit_enable` is low. A burst whose bits are spread out by idle cycles decodes the same as a dense burst.
- R9: After a valid or an error pulse, the decoder is hunting again. A burst that starts directly after the previous one decodes correctly.
- R10: `pkt_valid` and `pkt_error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_enable | input | 1 | Marks a cycle that carries a received bit |
| bit_in | input | 1 | Received bit value |
| set_sel | input | 4 | Static set number of the expected transmitter |
| pkt_valid | output | 1 | One-cycle pulse for a correctly decoded burst |
| pkt_error | output | 1 | One-cycle pulse for a burst with a bad code or bad ID |
| pkt_test | output | 1 | High with pkt_valid when the set is reserved for test devices |
| pkt_channel | output | 8 | Channel number of the last valid burst |
| pkt_data | output | 16 | Sample word of the last valid burst |

## Verification
The bench tests the preamble threshold at both sides of the limit. A decoder that counts off by one would either lock onto a 7-bit run or miss an 8-bit run. It sends payloads that contain long runs of ones. A decoder that kept hunting inside the payload would drop the packet and frame the wrong bits. It corrupts the completion code, and it sends IDs 0 and 15 with codes that match. This exposes a decoder that still pulses valid or that overwrites the held channel and data. Test sets, bursts with idle gaps full of toggling `bit_in`, and back-to-back bursts expose wrong test flags, bits sampled without an enable, and a decoder that fails to re-arm.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

   typedef enum logic [0:0] {
      DS_HUNT  = 1'b0,
      DS_FIELD = 1'b1
   } dec_state_e;

   // Expected completion code: all-ones minus ID plus set, truncated.
   function automatic logic [3:0] expect_code(input logic [3:0] id,
                                              input logic [3:0] set);
      logic [4:0] sum;
      sum = 5'd15 - {1'b0, id} + {1'b0, set};
      return sum[3:0];
   endfunction

endpackage

// File: rtl/bpd_sync_hunter.sv
module bpd_sync_hunter #(
   parameter int MIN_PREAMBLE = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic hunt_en,
   input  logic bit_enable,
   input  logic bit_in,
   output logic start_seen
);
   localparam int RUN_W = $clog2(MIN_PREAMBLE + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_PREAMBLE);

   generate
      if (MIN_PREAMBLE < 1) begin : g_bad_min
         $error("MIN_PREAMBLE must be at least 1");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;
   logic             run_full;

   assign run_full   = (run_q == RUN_MAX);
   assign start_seen = hunt_en & bit_enable & ~bit_in & run_full;

   always_ff @(posedge clk) begin
      if (rst || !hunt_en) begin
         run_q <= '0;
      end else if (bit_enable) begin
         if (bit_in) begin
            if (!run_full) run_q <= run_q + 1'b1;
         end else begin
            run_q <= '0;
         end
      end
   end

   // R2
   run_bound_chk: assert property (@(posedge clk) disable iff (rst)
      run_q <= RUN_MAX);

   // R2
   start_after_run_chk: assert property (@(posedge clk) disable iff (rst)
      start_seen |=> (run_q == '0));

endmodule

// File: rtl/bpd_field_shift.sv
module bpd_field_shift #(
   parameter int FRAME_W   = 24,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clear,
   input  logic               active,
   input  logic               bit_enable,
   input  logic               bit_in,
   output logic               last_bit,
   output logic [FRAME_W-1:0] frame_next
);
   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("FRAME_W must be at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               take;

   assign take     = active & bit_enable;
   assign last_bit = take & (cnt_q == CNT_LAST);

   generate
      if (MSB_FIRST) begin : g_msb
         assign frame_next = {shreg_q[FRAME_W-2:0], bit_in};
      end else begin : g_lsb
         assign frame_next = {bit_in, shreg_q[FRAME_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (take) begin
         shreg_q <= frame_next;
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!bit_enable && !clear) |=> $stable(shreg_q) && $stable(cnt_q));

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (rst)
      active |-> cnt_q <= CNT_LAST);

endmodule

// File: rtl/bpd_code_check.sv
module bpd_code_check #(
   parameter int ID_W         = 4,
   parameter int SET_W        = 4,
   parameter int TEST_SET_MIN = 14
) (
   input  logic [ID_W-1:0]  rx_id,
   input  logic [ID_W-1:0]  rx_code,
   input  logic [SET_W-1:0] set_sel,
   output logic             accept,
   output logic             test_set
);
   import bpd_pkg::*;

   localparam logic [ID_W-1:0] ID_LOW  = '0;
   localparam logic [ID_W-1:0] ID_HIGH = '1;

   generate
      if (ID_W != 4 || SET_W != 4) begin : g_bad_w
         $error("completion code rule is defined for 4-bit ID and set");
      end
   endgenerate

   logic id_ok;
   logic code_ok;

   assign id_ok    = (rx_id != ID_LOW) && (rx_id != ID_HIGH);
   assign code_ok  = (rx_code == expect_code(rx_id, set_sel));
   assign accept   = id_ok & code_ok;
   assign test_set = (set_sel >= SET_W'(TEST_SET_MIN));

endmodule

// File: rtl/burst_pkt_decoder.sv
module burst_pkt_decoder #(
   parameter int MIN_PREAMBLE = 8,
   parameter int ID_W         = 4,
   parameter int DATA_W       = 16,
   parameter int SET_W        = 4,
   parameter int TEST_SET_MIN = 14
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    bit_enable,
   input  logic                    bit_in,
   input  logic [SET_W-1:0]        set_sel,
   output logic                    pkt_valid,
   output logic                    pkt_error,
   output logic                    pkt_test,
   output logic [SET_W+ID_W-1:0]   pkt_channel,
   output logic [DATA_W-1:0]       pkt_data
);
   import bpd_pkg::*;

   localparam int CODE_W  = ID_W;
   localparam int FRAME_W = ID_W + DATA_W + CODE_W;
   localparam int CODE_LO = 0;
   localparam int DATA_LO = CODE_W;
   localparam int ID_LO   = CODE_W + DATA_W;

   dec_state_e         state_q;
   logic               hunting;
   logic               start_seen;
   logic               last_bit;
   logic [FRAME_W-1:0] frame_next;
   logic [ID_W-1:0]    rx_id;
   logic [DATA_W-1:0]  rx_data;
   logic [CODE_W-1:0]  rx_code;
   logic               accept;
   logic               test_set;

   assign hunting = (state_q == DS_HUNT);

   bpd_sync_hunter #(.MIN_PREAMBLE(MIN_PREAMBLE)) u_hunt (
      .clk        (clk),
      .rst        (rst),
      .hunt_en    (hunting),
      .bit_enable (bit_enable),
      .bit_in     (bit_in),
      .start_seen (start_seen)
   );

   bpd_field_shift #(.FRAME_W(FRAME_W), .MSB_FIRST(1'b1)) u_shift (
      .clk        (clk),
      .rst        (rst),
      .clear      (start_seen),
      .active     (!hunting),
      .bit_enable (bit_enable),
      .bit_in     (bit_in),
      .last_bit   (last_bit),
      .frame_next (frame_next)
   );

   assign rx_id   = frame_next[ID_LO   +: ID_W];
   assign rx_data = frame_next[DATA_LO +: DATA_W];
   assign rx_code = frame_next[CODE_LO +: CODE_W];

   bpd_code_check #(.ID_W(ID_W), .SET_W(SET_W), .TEST_SET_MIN(TEST_SET_MIN)) u_chk (
      .rx_id    (rx_id),
      .rx_code  (rx_code),
      .set_sel  (set_sel),
      .accept   (accept),
      .test_set (test_set)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= DS_HUNT;
         pkt_valid   <= 1'b0;
         pkt_error   <= 1'b0;
         pkt_test    <= 1'b0;
         pkt_channel <= '0;
         pkt_data    <= '0;
      end else begin
         pkt_valid <= 1'b0;
         pkt_error <= 1'b0;
         pkt_test  <= 1'b0;
         case (state_q)
            DS_HUNT: begin
               if (start_seen) state_q <= DS_FIELD;
            end
            DS_FIELD: begin
               if (last_bit) begin
                  state_q <= DS_HUNT;
                  if (accept) begin
                     pkt_valid   <= 1'b1;
                     pkt_test    <= test_set;
                     pkt_channel <= {set_sel, rx_id};
                     pkt_data    <= rx_data;
                  end else begin
                     pkt_error <= 1'b1;
                  end
               end
            end
            default: state_q <= DS_HUNT;
         endcase
      end
   end

   // R10
   excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      !(pkt_valid && pkt_error));

   // R4
   valid_single_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_valid |=> !pkt_valid);

   // R5
   err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_error |-> $stable(pkt_channel) && $stable(pkt_data));

   // R9
   rearm_chk: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid || pkt_error) |-> state_q == DS_HUNT);

   // R7
   test_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_test |-> pkt_valid);

endmodule

// File: tb/sim_burst_pkt_decoder.sv
module sim_burst_pkt_decoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bit_enable = 1'b0;
   logic        bit_in = 1'b0;
   logic [3:0]  set_sel = 4'd0;
   logic        pkt_valid, pkt_error, pkt_test;
   logic [7:0]  pkt_channel;
   logic [15:0] pkt_data;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   logic early;
   logic gap_toggle = 1'b0;

   always #2.5 clk = ~clk;

   burst_pkt_decoder u0 (
      .clk(clk), .rst(rst), .bit_enable(bit_enable), .bit_in(bit_in),
      .set_sel(set_sel), .pkt_valid(pkt_valid), .pkt_error(pkt_error),
      .pkt_test(pkt_test), .pkt_channel(pkt_channel), .pkt_data(pkt_data)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] good_code(input logic [3:0] id, input logic [3:0] s);
      logic [4:0] t;
      t = 5'd15 - {1'b0, id} + {1'b0, s};
      return t[3:0];
   endfunction

   // One bit; on return the bench sits at the negedge after the taking edge.
   task automatic send_bit(input logic b, input int gap);
      @(negedge clk);
      bit_enable = 1'b1;
      bit_in = b;
      @(negedge clk);
      bit_enable = 1'b0;
      for (int g = 0; g < gap; g++) begin
         gap_toggle = ~gap_toggle;
         bit_in = gap_toggle;
         @(negedge clk);
      end
   endtask

   // Sends preamble, start bit and payload; early flags any pulse before the end.
   task automatic send_burst(input int ones, input logic [3:0] id,
                             input logic [15:0] data, input logic [3:0] code,
                             input int gap);
      logic [23:0] fr;
      fr = {id, data, code};
      early = 1'b0;
      for (int i = 0; i < ones; i++) begin
         send_bit(1'b1, gap);
         if (pkt_valid || pkt_error) early = 1'b1;
      end
      send_bit(1'b0, gap);
      if (pkt_valid || pkt_error) early = 1'b1;
      for (int i = 23; i >= 1; i--) begin
         send_bit(fr[i], gap);
         if (pkt_valid || pkt_error) early = 1'b1;
      end
      @(negedge clk);
      bit_enable = 1'b1;
      bit_in = fr[0];
      @(negedge clk);
      bit_enable = 1'b0;
   endtask

   task automatic expect_valid(input string tag, input logic [3:0] id,
                               input logic [15:0] data, input logic tst);
      check(!early, {tag, " no early pulse (R4)"}, early, 0);
      check(pkt_valid && !pkt_error, {tag, " valid pulse R4 R10"},
            {pkt_valid, pkt_error}, 2'b10);
      check(pkt_channel == {set_sel, id}, {tag, " channel R7"}, pkt_channel, {set_sel, id});
      check(pkt_data == data, {tag, " data R3"}, pkt_data, data);
      check(pkt_test == tst, {tag, " test flag R7"}, pkt_test, tst);
      @(negedge clk);
      check(!pkt_valid && !pkt_test, {tag, " pulse one cycle R4"}, {pkt_valid, pkt_test}, 0);
   endtask

   task automatic expect_error(input string tag, input logic [7:0] ch,
                               input logic [15:0] data);
      check(!early, {tag, " no early pulse"}, early, 0);
      check(pkt_error && !pkt_valid, {tag, " error pulse R5 R6"},
            {pkt_valid, pkt_error}, 2'b01);
      check(pkt_channel == ch && pkt_data == data, {tag, " outputs held R5"},
            {pkt_channel, pkt_data}, {ch, data});
      @(negedge clk);
      check(!pkt_error, {tag, " error one cycle"}, pkt_error, 0);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(!pkt_valid && !pkt_error && !pkt_test && pkt_channel == 0 && pkt_data == 0,
            "R1 reset state", {pkt_valid, pkt_error, pkt_test, pkt_channel, pkt_data}, 0);
   endtask

   task automatic t_basic;
      set_sel = 4'd2;
      send_burst(11, 4'd5, 16'hA5C3, good_code(4'd5, 4'd2), 0);
      expect_valid("R2 basic 11-bit preamble", 4'd5, 16'hA5C3, 1'b0);
   endtask

   task automatic t_threshold;
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 7; i++) send_bit(1'b1, 0);
      send_bit(1'b0, 0);
      for (int i = 0; i < 24; i++) begin
         send_bit(1'b0, 0);
         if (pkt_valid || pkt_error) seen = 1'b1;
      end
      check(!seen, "R2 seven ones do not start", seen, 0);
      set_sel = 4'd1;
      send_burst(8, 4'd9, 16'h1234, good_code(4'd9, 4'd1), 0);
      expect_valid("R2 exactly eight ones", 4'd9, 16'h1234, 1'b0);
   endtask

   task automatic t_ones_payload;
      set_sel = 4'd4;
      send_burst(11, 4'd14, 16'hFFFF, good_code(4'd14, 4'd4), 0);
      expect_valid("R3 ones in payload", 4'd14, 16'hFFFF, 1'b0);
   endtask

   task automatic t_bad_code;
      logic [7:0] ch;
      logic [15:0] d;
      ch = pkt_channel;
      d = pkt_data;
      send_burst(11, 4'd6, 16'h0F0F, good_code(4'd6, 4'd4) ^ 4'd1, 0);
      expect_error("R5 code mismatch", ch, d);
   endtask

   task automatic t_bad_id;
      logic [7:0] ch;
      logic [15:0] d;
      ch = pkt_channel;
      d = pkt_data;
      send_burst(11, 4'd0, 16'h5555, good_code(4'd0, 4'd4), 0);
      expect_error("R6 id zero", ch, d);
      send_burst(11, 4'd15, 16'hAAAA, good_code(4'd15, 4'd4), 0);
      expect_error("R6 id fifteen", ch, d);
   endtask

   task automatic t_test_sets;
      set_sel = 4'd14;
      send_burst(11, 4'd3, 16'hBEEF, good_code(4'd3, 4'd14), 0);
      expect_valid("R7 set 14 test", 4'd3, 16'hBEEF, 1'b1);
      set_sel = 4'd15;
      send_burst(11, 4'd1, 16'h0001, good_code(4'd1, 4'd15), 0);
      expect_valid("R7 set 15 test", 4'd1, 16'h0001, 1'b1);
      set_sel = 4'd13;
      send_burst(11, 4'd14, 16'h8000, good_code(4'd14, 4'd13), 0);
      expect_valid("R7 set 13 normal", 4'd14, 16'h8000, 1'b0);
   endtask

   task automatic t_gaps;
      set_sel = 4'd7;
      send_burst(11, 4'd10, 16'h6C39, good_code(4'd10, 4'd7), 3);
      expect_valid("R8 gapped bits", 4'd10, 16'h6C39, 1'b0);
   endtask

   task automatic t_back_to_back;
      set_sel = 4'd0;
      send_burst(11, 4'd2, 16'h4321, good_code(4'd2, 4'd0), 0);
      check(pkt_valid, "R9 first of pair", pkt_valid, 1);
      send_burst(11, 4'd12, 16'h9876, good_code(4'd12, 4'd0), 0);
      expect_valid("R9 second of pair", 4'd12, 16'h9876, 1'b0);
      send_burst(11, 4'd8, 16'h1111, 4'd0, 0);
      check(pkt_error, "R9 error burst", pkt_error, 1);
      send_burst(11, 4'd8, 16'h2222, good_code(4'd8, 4'd0), 0);
      expect_valid("R9 after error", 4'd8, 16'h2222, 1'b0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_threshold();
      t_ones_payload();
      t_bad_code();
      t_bad_id();
      t_test_sets();
      t_gaps();
      t_back_to_back();
      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule